// File: doc/BRIEF.md
# Spread-Spectrum Triangular Sweep Generator

This block is the digital side of a frequency-modulated clock synthesizer. It produces the value of a fractional feedback divider: a nominal multiplier plus a signed offset that follows a repeating triangle. Sweeping the divider this way moves the synthesized clock up and down in frequency, which spreads its emission peaks over a band. The oscillator, the phase comparison and the loop filter sit outside this block.

Configuration comes from a register file elsewhere in the chip. It holds the nominal divider value in 8.16 fixed point, a sweep depth in fractional counts, the length of a quarter of the sweep period in reference updates, and a choice between a profile centred on nominal and a profile that only moves downward. A reference tick marks each update. On every tick the block emits a new divider value and pulses a strobe. An enable input starts and stops the sweep at run time. When the sweep is stopped, the output falls back to exactly the nominal value. When it is started again, the sweep begins at the phase where the offset is zero.

The ramp is exact. The offset at step k of a ramp is floor(D·k/Q), and it reaches the peak on the update at exactly half the period. Depth, quarter length and profile changes are only taken over at a period boundary, so a running sweep never jumps.

Top module: `ssm_sweep_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `div_out` is 0 and `div_strobe` is 0.
- R2: `div_strobe` is high for exactly the one cycle after each clock edge with `ref_tick` high. `div_out` takes its new value on that same edge. The strobe is low at all other times.
- R3: On an update with `mod_en` low, `div_out` equals `nominal` exactly.
- R4: With depth D and quarter length Q, the unsigned ramp is u(k)=floor(D·k/Q) for phase k in 0..2Q and u(4Q−k) for k in 2Q..4Q−1. The phase advances by one per enabled update and wraps after 4Q updates.
- R5: With `down_mode`=0 (centred), the offset is u(k)−D. The first enabled update after a start has phase k=Q (offset 0). The peak of +D comes Q updates later, and the trough of −D comes 3Q updates after the start.
- R6: With `down_mode`=1 (downshift), the offset is −u(k). The first enabled update after a start has phase k=0. The output never exceeds `nominal` and reaches `nominal`−2D at phase 2Q.
- R7: After `mod_en` falls, the next update outputs `nominal`. When it rises again, the first update carries offset 0 and the sweep continues from the zero phase of the profile selected at that time.
- R8: A change to depth, quarter length or profile takes effect at the first period wrap (or enable start) that comes more than 2·(DEPTH_W+1) clock cycles after the change. Until then the current period keeps the old settings.
- R9: A quarter length of 0 is treated as 1.
- R10: `nominal` is taken on every update. The output is (`nominal` + offset) modulo 2^NOM_W.
- R11: Without `ref_tick`, `div_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse marking a reference update |
| mod_en | input | 1 | Sweep enable; low forces the nominal value |
| down_mode | input | 1 | 0 = centred profile, 1 = downshift-only profile |
| nominal | input | NOM_W (24) | Nominal divider value, 8 integer and 16 fractional bits |
| depth | input | DEPTH_W (20) | Sweep depth D in fractional counts |
| quarter | input | QTR_W (12) | Quarter of the sweep period, in updates |
| div_out | output | NOM_W (24) | Modulated divider value |
| div_strobe | output | 1 | Pulses for one cycle with each new divider value |

## Verification
The bench builds the block with its default widths: 24-bit divider value, 20-bit depth and 12-bit quarter length. This covers the default sweep of 160 updates with a depth of 2% of a 64.0 multiplier, as well as depths up to 2^17 where the remainder carry in the ramp fires on most steps. Quarter lengths from 0 to 40 make period wraps frequent. Together with a 21-cycle divider round, this lets the bench place a settings change in the middle of a period and observe exactly which wrap takes it over.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Sweep profile selection.
  typedef enum logic {
    SWEEP_CENTER = 1'b0,
    SWEEP_DOWN   = 1'b1
  } sweep_e;

endpackage

// File: rtl/ssm_cfg_div.sv
// Continuously divides the requested depth by the quarter length and
// publishes the quotient and remainder together with the operands they
// belong to, so that the stepper can take over a coherent set at once.
module ssm_cfg_div
  import ssm_pkg::*;
#(
  parameter int DEPTH_W = 20,
  parameter int QTR_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [QTR_W-1:0]   quarter_i,
  input  logic               mode_i,
  output logic [DEPTH_W-1:0] rdy_depth,
  output logic [QTR_W-1:0]   rdy_quarter,
  output sweep_e             rdy_mode,
  output logic [DEPTH_W-1:0] rdy_quo,
  output logic [QTR_W-1:0]   rdy_rem
);

  localparam int CNT_W = $clog2(DEPTH_W) + 1;
  localparam int PW    = DEPTH_W + QTR_W;

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [DEPTH_W-1:0] opd_d;
  logic [QTR_W-1:0]   opd_q;
  sweep_e             opd_m;
  logic [DEPTH_W-1:0] quo;
  logic [QTR_W-1:0]   rem;

  logic [QTR_W:0]     rem_sh;
  logic               fits;
  logic [QTR_W:0]     rem_nx;
  logic [DEPTH_W-1:0] quo_nx;

  // One restoring step per clock.
  always_comb begin
    rem_sh = {rem, quo[DEPTH_W-1]};
    fits   = rem_sh >= {1'b0, opd_q};
    rem_nx = fits ? (rem_sh - {1'b0, opd_q}) : rem_sh;
    quo_nx = {quo[DEPTH_W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      opd_d       <= '0;
      opd_q       <= QTR_W'(1);
      opd_m       <= SWEEP_CENTER;
      quo         <= '0;
      rem         <= '0;
      rdy_depth   <= '0;
      rdy_quarter <= QTR_W'(1);
      rdy_mode    <= SWEEP_CENTER;
      rdy_quo     <= '0;
      rdy_rem     <= '0;
    end else if (!busy) begin
      opd_d <= depth_i;
      opd_q <= (quarter_i == '0) ? QTR_W'(1) : quarter_i;
      opd_m <= sweep_e'(mode_i);
      quo   <= depth_i;
      rem   <= '0;
      cnt   <= '0;
      busy  <= 1'b1;
    end else begin
      quo <= quo_nx;
      rem <= rem_nx[QTR_W-1:0];
      cnt <= cnt + CNT_W'(1);
      if (cnt == CNT_W'(DEPTH_W - 1)) begin
        busy        <= 1'b0;
        rdy_depth   <= opd_d;
        rdy_quarter <= opd_q;
        rdy_mode    <= opd_m;
        rdy_quo     <= quo_nx;
        rdy_rem     <= rem_nx[QTR_W-1:0];
      end
    end
  end

  // R4: published quotient and remainder reproduce the depth exactly.
  a_r4_div_exact: assert property (@(posedge clk) disable iff (rst)
    (PW'(rdy_quo) * PW'(rdy_quarter) + PW'(rdy_rem)) == PW'(rdy_depth)
    && rdy_rem < rdy_quarter);

  // R9: a zero quarter length never reaches the stepper.
  a_r9_quarter_nonzero: assert property (@(posedge clk) disable iff (rst)
    rdy_quarter != '0);

endmodule

// File: rtl/ssm_tri.sv
// Triangle stepper: exact linear ramp through a quotient/remainder
// accumulator, mirrored on the way down.
module ssm_tri
  import ssm_pkg::*;
#(
  parameter int DEPTH_W = 20,
  parameter int QTR_W   = 12,
  localparam int OFF_W  = DEPTH_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    en,
  input  logic [DEPTH_W-1:0]      c_depth,
  input  logic [QTR_W-1:0]        c_quarter,
  input  sweep_e                  c_mode,
  input  logic [DEPTH_W-1:0]      c_quo,
  input  logic [QTR_W-1:0]        c_rem,
  output logic signed [OFF_W-1:0] offset
);

  localparam int K_W = QTR_W + 2;
  localparam int V_W = DEPTH_W + 1;

  logic [DEPTH_W-1:0] a_depth;
  logic [QTR_W-1:0]   a_quarter;
  sweep_e             a_mode;
  logic [DEPTH_W-1:0] a_quo;
  logic [QTR_W-1:0]   a_rem;

  logic [K_W-1:0]     k;
  logic [V_W-1:0]     v;
  logic [QTR_W-1:0]   e;

  logic [K_W-1:0]     k_last;
  logic [K_W-1:0]     k_half;
  logic               rising;
  logic [QTR_W:0]     e_up;
  logic               carry;
  logic [QTR_W:0]     e_up_nx;
  logic [V_W-1:0]     v_up;
  logic               borrow;
  logic [V_W-1:0]     v_dn;
  logic [QTR_W-1:0]   e_dn;

  always_comb begin
    k_last  = {a_quarter, 2'b00} - K_W'(1);
    k_half  = {1'b0, a_quarter, 1'b0};
    rising  = k < k_half;
    e_up    = {1'b0, e} + {1'b0, a_rem};
    carry   = e_up >= {1'b0, a_quarter};
    e_up_nx = carry ? (e_up - {1'b0, a_quarter}) : e_up;
    v_up    = v + V_W'(a_quo) + V_W'(carry);
    borrow  = e < a_rem;
    v_dn    = v - V_W'(a_quo) - V_W'(borrow);
    e_dn    = borrow ? (e + a_quarter - a_rem) : (e - a_rem);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_depth   <= '0;
      a_quarter <= QTR_W'(1);
      a_mode    <= SWEEP_CENTER;
      a_quo     <= '0;
      a_rem     <= '0;
      k         <= '0;
      v         <= '0;
      e         <= '0;
    end else if (!en) begin
      // Parked at the zero-offset phase of the latest settings.
      a_depth   <= c_depth;
      a_quarter <= c_quarter;
      a_mode    <= c_mode;
      a_quo     <= c_quo;
      a_rem     <= c_rem;
      e         <= '0;
      if (c_mode == SWEEP_DOWN) begin
        k <= '0;
        v <= '0;
      end else begin
        k <= {2'b00, c_quarter};
        v <= {1'b0, c_depth};
      end
    end else if (tick) begin
      if (k == k_last) begin
        a_depth   <= c_depth;
        a_quarter <= c_quarter;
        a_mode    <= c_mode;
        a_quo     <= c_quo;
        a_rem     <= c_rem;
        k         <= '0;
        v         <= '0;
        e         <= '0;
      end else if (rising) begin
        k <= k + K_W'(1);
        v <= v_up;
        e <= e_up_nx[QTR_W-1:0];
      end else begin
        k <= k + K_W'(1);
        v <= v_dn;
        e <= e_dn;
      end
    end
  end

  always_comb begin
    if (a_mode == SWEEP_DOWN) offset = -$signed({1'b0, v});
    else                      offset = $signed({1'b0, v}) - $signed({2'b00, a_depth});
  end

  // R4: ramp stays between zero and twice the depth.
  a_r4_ramp_bound: assert property (@(posedge clk) disable iff (rst)
    {1'b0, v} <= {1'b0, a_depth, 1'b0});

  // R4: accumulator remainder stays below the quarter length.
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
    e < a_quarter);

  // R4: phase never passes the end of the period.
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (rst)
    k <= k_last);

  // R4: each rising step adds the quotient, plus one on a carry.
  a_r4_rise_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && en && $past(en) && $past(tick) && $past(rising))
    |-> (v == $past(v) + V_W'($past(a_quo))
         || v == $past(v) + V_W'($past(a_quo)) + V_W'(1)));

  // R8: active settings change only when parked or at a period wrap.
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable({a_depth, a_quarter, a_mode}))
    |-> (!$past(en) || ($past(tick) && $past(k) == $past(k_last))));

endmodule

// File: rtl/ssm_sweep_gen.sv
module ssm_sweep_gen
  import ssm_pkg::*;
#(
  parameter int NOM_W   = 24,
  parameter int DEPTH_W = 20,
  parameter int QTR_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_tick,
  input  logic               mod_en,
  input  logic               down_mode,
  input  logic [NOM_W-1:0]   nominal,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [QTR_W-1:0]   quarter,
  output logic [NOM_W-1:0]   div_out,
  output logic               div_strobe
);

  localparam int OFF_W = DEPTH_W + 2;
  localparam int SUM_W = ((NOM_W > OFF_W) ? NOM_W : OFF_W) + 1;

  logic [DEPTH_W-1:0]      r_depth;
  logic [QTR_W-1:0]        r_quarter;
  sweep_e                  r_mode;
  logic [DEPTH_W-1:0]      r_quo;
  logic [QTR_W-1:0]        r_rem;
  logic signed [OFF_W-1:0] offset;
  logic signed [SUM_W-1:0] sum;

  ssm_cfg_div #(.DEPTH_W(DEPTH_W), .QTR_W(QTR_W)) u_div (
    .clk         (clk),
    .rst         (rst),
    .depth_i     (depth),
    .quarter_i   (quarter),
    .mode_i      (down_mode),
    .rdy_depth   (r_depth),
    .rdy_quarter (r_quarter),
    .rdy_mode    (r_mode),
    .rdy_quo     (r_quo),
    .rdy_rem     (r_rem)
  );

  ssm_tri #(.DEPTH_W(DEPTH_W), .QTR_W(QTR_W)) u_tri (
    .clk       (clk),
    .rst       (rst),
    .tick      (ref_tick),
    .en        (mod_en),
    .c_depth   (r_depth),
    .c_quarter (r_quarter),
    .c_mode    (r_mode),
    .c_quo     (r_quo),
    .c_rem     (r_rem),
    .offset    (offset)
  );

  always_comb begin
    sum = SUM_W'($signed({1'b0, nominal})) + SUM_W'(offset);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out    <= '0;
      div_strobe <= 1'b0;
    end else begin
      div_strobe <= ref_tick;
      if (ref_tick) div_out <= mod_en ? sum[NOM_W-1:0] : nominal;
    end
  end

  // R2: every tick yields a strobe on the next cycle.
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> div_strobe);

  // R11: no tick, no strobe and no change of the output.
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> (!div_strobe && $stable(div_out)));

  // R3: a disabled update passes the nominal value through.
  a_r3_nominal_when_off: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !mod_en) |=> (div_out == $past(nominal)));

endmodule

// File: tb/tb_ssm_sweep_gen.sv
module tb_ssm_sweep_gen;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ref_tick;
  logic        mod_en;
  logic        down_mode;
  logic [23:0] nominal;
  logic [19:0] depth;
  logic [11:0] quarter;
  logic [23:0] div_out;
  logic        div_strobe;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     finished = 0;
  longint m_k, m_D, m_Q;
  bit     m_down;
  longint hi_v, lo_v, first_v, last_v;

  always #(CLK_P/2) clk = ~clk;

  ssm_sweep_gen dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .mod_en(mod_en),
    .down_mode(down_mode), .nominal(nominal), .depth(depth),
    .quarter(quarter), .div_out(div_out), .div_strobe(div_strobe)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint ramp(input longint d, input longint q, input longint k);
    if (k <= 2*q) return (d*k)/q;
    return (d*(4*q - k))/q;
  endfunction

  function automatic longint expect_out();
    longint off;
    if (!mod_en) return longint'(nominal);
    off = m_down ? -ramp(m_D, m_Q, m_k) : ramp(m_D, m_Q, m_k) - m_D;
    return (longint'(nominal) + off) & 64'hFFFFFF;
  endfunction

  task automatic load_model();
    m_D    = longint'(depth);
    m_Q    = (quarter == 0) ? 1 : longint'(quarter);
    m_down = down_mode;
  endtask

  task automatic start_sweep();
    mod_en = 1'b1;
    load_model();
    m_k = m_down ? 0 : m_Q;
  endtask

  // Starts and ends at a falling edge.
  task automatic do_tick(input string tag);
    longint e;
    e = expect_out();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(tag, longint'(div_out), e);
    chk("R2 strobe after tick", longint'(div_strobe), 1);
    last_v = longint'(div_out);
    if (mod_en) begin
      if (m_k == 4*m_Q - 1) begin
        m_k = 0;
        load_model();
      end else begin
        m_k++;
      end
    end
  endtask

  task automatic idle(input int n);
    longint held;
    held = longint'(div_out);
    repeat (n) @(negedge clk);
    chk("R11 hold without tick", longint'(div_out), held);
    chk("R2 no strobe without tick", longint'(div_strobe), 0);
  endtask

  task automatic settle();
    mod_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic run(input string tag, input longint n, input bit gaps);
    hi_v = -1; lo_v = 64'h7FFFFFFF;
    for (longint i = 0; i < n; i++) begin
      do_tick(tag);
      if (i == 0) first_v = last_v;
      if (last_v > hi_v) hi_v = last_v;
      if (last_v < lo_v) lo_v = last_v;
      if (gaps && ($urandom % 4 == 0)) idle(1 + ($urandom % 2));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; ref_tick = 1'b0; mod_en = 1'b0; down_mode = 1'b0;
    nominal = 24'h400000; depth = 20'd83886; quarter = 12'd40;
    repeat (5) @(negedge clk);
    chk("R1 reset output", longint'(div_out), 0);
    chk("R1 reset strobe", longint'(div_strobe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 output after reset", longint'(div_out), 0);
    chk("R1 strobe after reset", longint'(div_strobe), 0);

    // R3: disabled updates are nominal.
    settle();
    do_tick("R3 disabled update");
    idle(2);
    do_tick("R3 disabled update");

    // R5: default centred sweep, 160 updates per period.
    start_sweep();
    run("R5 centred default", 4*m_Q, 0);
    chk("R5 peak +D", hi_v, 24'h400000 + 83886);
    chk("R5 trough -D", lo_v, 24'h400000 - 83886);
    chk("R5 first update offset zero", first_v, 24'h400000);
    do_tick("R4 period wrap");
    chk("R4 period of 4Q updates", last_v, first_v);

    // R6: default downshift sweep.
    down_mode = 1'b1;
    settle();
    start_sweep();
    run("R6 downshift default", 4*m_Q, 1);
    chk("R6 never above nominal", hi_v, 24'h400000);
    chk("R6 trough -2D", lo_v, 24'h400000 - 2*83886);
    chk("R6 first update nominal", first_v, 24'h400000);
    do_tick("R4 period wrap");
    chk("R4 period of 4Q updates", last_v, first_v);

    // R7: stop mid-sweep and restart.
    down_mode = 1'b0; depth = 20'd4000; quarter = 12'd8;
    settle();
    start_sweep();
    run("R7 before stop", 13, 0);
    mod_en = 1'b0;
    do_tick("R7 nominal after stop");
    do_tick("R7 still nominal");
    start_sweep();
    do_tick("R7 restart at zero offset");
    chk("R7 restart value", last_v, 24'h400000);
    run("R7 after restart", 10, 1);

    // R8: settings change mid-period applies only at the wrap.
    down_mode = 1'b1; depth = 20'd1000; quarter = 12'd10;
    settle();
    start_sweep();
    for (int i = 0; i < 5; i++) do_tick("R8 old settings");
    depth = 20'd2000;
    for (int i = 0; i < 35; i++) begin
      do_tick("R8 old settings until wrap");
      idle(1);
    end
    chk("R8 wrap loaded new depth", m_D, 2000);
    run("R8 new settings", 40, 0);
    chk("R8 new trough", lo_v, 24'h400000 - 4000);

    // R9: zero quarter length acts as one.
    depth = 20'd5; quarter = 12'd0;
    settle();
    start_sweep();
    run("R9 quarter zero", 8, 0);
    chk("R9 trough", lo_v, 24'h400000 - 10);

    // R10: nominal is taken live.
    down_mode = 1'b0; depth = 20'd3000; quarter = 12'd6;
    settle();
    start_sweep();
    run("R10 before change", 5, 0);
    nominal = 24'h3A1234;
    do_tick("R10 new nominal");
    run("R10 after change", 10, 1);

    // Random configurations.
    for (int t = 0; t < 8; t++) begin
      down_mode = 1'($urandom % 2);
      depth     = 20'($urandom % (1 << 17));
      quarter   = 12'(1 + ($urandom % 30));
      nominal   = 24'(24'h300000 + ($urandom % 24'h200000));
      settle();
      start_sweep();
      run(down_mode ? "R6 random downshift" : "R5 random centred", 8*m_Q + 3, 1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule